// File: doc/BRIEF.md
# Dual-Divider Serial Peripheral Master

This block is a register-mapped master for SPI framing that moves 8-bit words. Software pushes words into an 8-entry transmit queue and pops replies from an 8-entry receive queue. A serial engine shifts each queued word out on `mosi`, most significant bit first, and gathers one reply word from `miso` in the same frame. The serial clock comes from two dividers in series. An even prescaler sets the base rate and a second stage divides it by (1 + rate field). All four combinations of idle level and capture edge are supported.

A small synchronous register port gives access to six word locations: two control registers, the data window, a status word, the prescaler, and an interrupt status/clear word. An internal loopback feeds the engine's own output back to its input. A raised overrun condition latches until software clears it. Chip selection is left to external logic. Software waits for the busy flag to drop before it releases the select.

Top module: `spim_top`

## Requirements
- R1: After reset the status word (offset 0x0C) reads 0x0003 (bit0 transmit-empty = 1, bit1 transmit-not-full = 1, bit2 receive-not-empty = 0, bit3 receive-full = 0, bit4 busy = 0), `sclk` is 0 and `irq` is 0.
- R2: One serial bit lasts P × (1 + S) clock cycles. S is control-0 bits 15:8. P is the prescale register (offset 0x10) with bit 0 forced to 0, and any P below 2 acts as 2. The prescale register reads back with bit 0 = 0.
- R3: While no frame is in progress, `sclk` rests at the level of control-0 bit 6.
- R4: Control-0 bit 7 selects the capture edge. When it is 0, `miso` is sampled on the first edge of each bit and `mosi` changes on the second edge. When it is 1, `mosi` changes on the first edge and `miso` is sampled on the second edge. Data goes most significant bit first, and each word written to offset 0x08 yields exactly one received word.
- R5: When control-1 bit 3 is 1, the receive path takes the block's own `mosi` value, and the level on `miso` has no effect on received data.
- R6: While control-1 bit 4 (port enable) is 0, no frame starts, `sclk` stays idle and written words stay queued. A write to a full transmit queue is dropped.
- R7: Busy (status bit 4) stays 1 until the last queued frame has shifted all 8 bits. When it drops, the reply is already readable.
- R8: The receive queue holds 8 words, and a read of offset 0x08 pops the oldest. A frame that completes while the queue is full and not being popped is discarded and sets bit 2 of offset 0x14. That bit clears only when a 1 is written to bit 2 of offset 0x14.
- R9: Offset 0x14 reads {overrun, transmit-empty, receive-not-empty} in bits 2:0. `irq` is the OR of those bits masked by control-1 bits 2:0.
- R10: A receive pop and a frame completion in the same cycle lose no word and keep word order.
- R11: Control 0 reads back all 16 bits, and control 1 reads back bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at offset 0x08) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can fall into the same clock cycle: a frame finishing and pushing its reply, and software popping the receive queue through the data window. A second pair works the same way at the other end, where a bus write to a queue is being drained by the shifter in that cycle. Both are provoked by streaming words at the fastest rate in loopback while reads and writes are issued at random points in time. The received sequence is then compared word by word with the sent one. The full-queue variant is judged separately: nine frames land without any pop, and the test confirms that exactly the first eight survive in order and the overrun flag latches.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL0 = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 6'h04;
  localparam logic [ADDR_W-1:0] A_DATA  = 6'h08;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_PRE   = 6'h10;
  localparam logic [ADDR_W-1:0] A_ISR   = 6'h14;

  // half of the effective even prescale; values below 2 behave as 2
  function automatic logic [DIV_W-2:0] pre_half(input logic [DIV_W-1:0] pre);
    return (pre[DIV_W-1:1] == '0) ? (DIV_W-1)'(1) : pre[DIV_W-1:1];
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  // R8
  fifo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> $stable(count));
  // R10
  fifo_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] pre,
  input  logic [DIV_W-1:0] rate,
  output logic             tick
);
  logic [DIV_W-2:0] pre_cnt, pre_lim;
  logic [DIV_W-1:0] rate_cnt;
  logic             pre_end;

  assign pre_lim = pre_half(pre) - (DIV_W-1)'(1);
  assign pre_end = (pre_cnt == pre_lim);
  assign tick    = run && pre_end && (rate_cnt == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0; rate_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0; rate_cnt <= '0;
    end else if (pre_end) begin
      pre_cnt  <= '0;
      rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + DIV_W'(1);
    end else begin
      pre_cnt <= pre_cnt + (DIV_W-1)'(1);
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          loop,
  input  logic          tick,
  input  logic          tx_avail,
  input  logic [FW-1:0] tx_data,
  input  logic          miso,
  output logic          start,
  output logic          active,
  output logic          frame_done,
  output logic          sclk,
  output logic          mosi,
  output logic [FW-1:0] rx_data
);
  localparam int EW = $clog2(2 * FW);
  localparam logic [EW-1:0] LAST = EW'(2 * FW - 1);

  logic [EW-1:0] ecnt;
  logic [FW-1:0] tx_sh, rx_sh;
  logic          sclk_q, mosi_q, act_q, miso_eff, leading;

  assign miso_eff   = loop ? mosi_q : miso;
  assign leading    = ~ecnt[0];
  assign frame_done = act_q && tick && (ecnt == LAST);
  assign start      = en && tx_avail && (!act_q || frame_done);
  assign rx_data    = cpha ? {rx_sh[FW-2:0], miso_eff} : rx_sh;
  assign active     = act_q;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      ecnt <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!en) begin
      act_q <= 1'b0; sclk_q <= cpol; ecnt <= '0;
    end else begin
      if (act_q && tick) begin
        sclk_q <= ~sclk_q;
        ecnt   <= ecnt + EW'(1);
        if (leading == !cpha) begin
          rx_sh <= {rx_sh[FW-2:0], miso_eff};
        end else if (cpha || ecnt != LAST) begin
          mosi_q <= tx_sh[FW-1];
          tx_sh  <= {tx_sh[FW-2:0], 1'b0};
        end
        if (ecnt == LAST) act_q <= 1'b0;
      end else if (!act_q) begin
        sclk_q <= cpol;
      end
      if (start) begin
        act_q <= 1'b1;
        ecnt  <= '0;
        if (!cpha) begin
          mosi_q <= tx_data[FW-1];
          tx_sh  <= {tx_data[FW-2:0], 1'b0};
        end else begin
          tx_sh <= tx_data;
        end
      end
    end
  end

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && $past(!act_q) && $stable(cpol) && $past(en)) |-> (sclk_q == cpol));
  // R4
  tick_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> act_q);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int FW         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic [15:0]      ctrl0;
  logic [6:0]       ctrl1;
  logic [DIV_W-1:0] pre_q;
  logic             ovr_q;

  logic port_en, loop_en, cpol, cpha;
  logic tx_push, tx_empty, tx_full, rx_pop, rx_empty, rx_full;
  logic start, active, frame_done, tick, busy, ovr_event;
  logic [FW-1:0] tx_head, rx_head, rx_word;
  logic [2:0]    ris;

  assign port_en = ctrl1[4];
  assign loop_en = ctrl1[3];
  assign cpha    = ctrl0[7];
  assign cpol    = ctrl0[6];

  assign tx_push   = reg_wr && (reg_addr == A_DATA);
  assign rx_pop    = reg_rd && (reg_addr == A_DATA);
  assign ovr_event = frame_done && rx_full && !(rx_pop && !rx_empty);
  assign busy      = active || (port_en && !tx_empty);
  assign ris       = {ovr_q, tx_empty, !rx_empty};
  assign irq       = |(ris & ctrl1[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0 <= '0; ctrl1 <= '0; pre_q <= '0; ovr_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL0: ctrl0 <= reg_wdata;
          A_CTRL1: ctrl1 <= reg_wdata[6:0];
          A_PRE:   pre_q <= {reg_wdata[DIV_W-1:1], 1'b0};
          default: ;
        endcase
      end
      if (ovr_event) ovr_q <= 1'b1;
      else if (reg_wr && reg_addr == A_ISR && reg_wdata[2]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL0: reg_rdata = ctrl0;
      A_CTRL1: reg_rdata = {9'd0, ctrl1};
      A_DATA:  reg_rdata = rx_empty ? 16'd0 : 16'(rx_head);
      A_STAT:  reg_rdata = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      A_PRE:   reg_rdata = 16'(pre_q);
      A_ISR:   reg_rdata = {13'd0, ris};
      default: reg_rdata = 16'd0;
    endcase
  end

  spim_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) tx_q (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(start), .din(reg_wdata[FW-1:0]),
    .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) rx_q (
    .clk(clk), .rst_n(rst_n), .push(frame_done), .pop(rx_pop), .din(rx_word),
    .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spim_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(active && port_en), .pre(pre_q),
    .rate(ctrl0[15:8]), .tick(tick));

  spim_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(port_en), .cpol(cpol), .cpha(cpha), .loop(loop_en),
    .tick(tick), .tx_avail(!tx_empty), .tx_data(tx_head), .miso(miso),
    .start(start), .active(active), .frame_done(frame_done),
    .sclk(sclk), .mosi(mosi), .rx_data(rx_word));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && port_en && $past(port_en)) |-> $past(frame_done));
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> ris[2]);
  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !active);
endmodule

// File: tb/spim_top_tb_top.sv
`timescale 1ns/1ps
module spim_top_tb_top;
  localparam logic [5:0] A_C0 = 6'h00, A_C1 = 6'h04, A_DT = 6'h08,
                         A_ST = 6'h0C, A_PR = 6'h10, A_IS = 6'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk, mosi, miso;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // serial slave model
  logic mon_en = 0, cpha_tb = 0, idle_miso = 0, c1_bit = 0;
  logic [7:0] slv_sh = '0, cap = '0;
  int eno = 0;

  assign miso = mon_en ? (cpha_tb ? c1_bit : slv_sh[7]) : idle_miso;

  spim_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso));

  always #2.5 clk = ~clk;

  always @(sclk) if (mon_en) begin
    #1;
    if (eno % 2 == 0) begin
      if (!cpha_tb) cap = {cap[6:0], mosi};
      else begin c1_bit = slv_sh[7]; slv_sh = {slv_sh[6:0], 1'b0}; end
    end else begin
      if (cpha_tb) cap = {cap[6:0], mosi};
      else slv_sh = {slv_sh[6:0], 1'b0};
    end
    eno++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      done = 1;
      summary();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_period(input int pre, input int scr);
    int e;
    e = pre - (pre % 2);
    if (e < 2) e = 2;
    return e * (scr + 1);
  endfunction

  function automatic logic [15:0] c0(input int scr, input bit ph, input bit pol);
    return 16'((scr << 8) | (ph << 7) | (pol << 6) | 7);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] s;
    n = 0;
    for (int k = 0; k < 20000; k++) begin
      rd(A_ST, s); n += 2;
      if (!s[4]) break;
    end
  endtask

  task automatic meas(output int n);
    logic p;
    p = sclk;
    while (sclk == p) @(negedge clk);
    n = 0; p = sclk;
    for (int j = 0; j < 2; j++) begin
      while (sclk == p) begin @(negedge clk); n++; end
      p = sclk;
    end
  endtask

  logic [15:0] d;
  logic [7:0] sent [64];
  int n, ns, nr;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_ST, d);
    check("R1 status", d, 16'h0003);
    check("R1 sclk", sclk, 0);
    check("R1 irq", irq, 0);

    // R11 readback, R2 prescale bit0
    wr(A_C0, 16'hA5C7); rd(A_C0, d); check("R11 ctrl0", d, 16'hA5C7);
    wr(A_C1, 16'h0048); rd(A_C1, d); check("R11 ctrl1", d, 16'h0048);
    wr(A_PR, 16'h0055); rd(A_PR, d); check("R2 prescale readback", d, 16'h0054);

    // R3 idle level follows polarity
    wr(A_C1, 16'h0010);
    wr(A_C0, c0(0, 0, 1)); repeat (3) @(negedge clk);
    check("R3 idle pol1", sclk, 1);
    wr(A_C0, c0(0, 0, 0)); repeat (3) @(negedge clk);
    check("R3 idle pol0", sclk, 0);

    // R2 bit period, directed + random
    for (int t = 0; t < 6; t++) begin
      int pr, sc;
      case (t)
        0: begin pr = 2; sc = 0; end
        1: begin pr = 4; sc = 2; end
        2: begin pr = 5; sc = 1; end
        3: begin pr = 0; sc = 3; end
        default: begin pr = 2 + $urandom % 12; sc = $urandom % 6; end
      endcase
      wr(A_PR, 16'(pr));
      wr(A_C0, c0(sc, 0, 0));
      wr(A_C1, 16'h0018);
      wr(A_DT, 16'h005A);
      meas(n);
      check("R2 bit period", n, exp_period(pr, sc));
      wait_idle(n);
      rd(A_DT, d);
    end

    // R7 busy holds for the whole frame
    wr(A_PR, 16'd4); wr(A_C0, c0(3, 0, 0)); wr(A_C1, 16'h0018);
    wr(A_DT, 16'h00C3);
    wait_idle(n);
    check("R7 busy lasts >= 8 bits", int'(n >= 8 * 16), 1);
    rd(A_ST, d); check("R7 reply ready at busy drop", d[2], 1);
    check("R7 sclk idle", sclk, 0);
    rd(A_DT, d); check("R7 data", d, 16'h00C3);

    // R4 four clock modes with external slave
    wr(A_PR, 16'd4);
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tx, sv;
      tx = 8'($urandom); sv = 8'($urandom);
      wr(A_C1, 16'h0000);
      wr(A_C0, c0(1, m[1], m[0]));
      wr(A_C1, 16'h0010);
      repeat (2) @(negedge clk);
      cpha_tb = m[1]; slv_sh = sv; c1_bit = 0; eno = 0; cap = 0; mon_en = 1;
      wr(A_DT, 16'(tx));
      wait_idle(n);
      #2;
      mon_en = 0;
      check("R4 mosi capture", cap, tx);
      rd(A_DT, d); check("R4 miso receive", d, 16'(sv));
      check("R3 idle after frame", sclk, m[0]);
    end

    // R5 loopback ignores miso
    wr(A_C0, c0(0, 0, 0)); wr(A_PR, 16'd2); wr(A_C1, 16'h0018);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] tx;
      tx = 8'($urandom);
      idle_miso = k[0];
      wr(A_DT, 16'(tx));
      wait_idle(n);
      rd(A_DT, d); check("R5 loopback data", d, 16'(tx));
    end
    idle_miso = 0;

    // R6 disabled port holds queue, 9th write dropped
    wr(A_C1, 16'h0008);
    for (int k = 0; k < 9; k++) begin sent[k] = 8'($urandom); wr(A_DT, 16'(sent[k])); end
    repeat (40) @(negedge clk);
    rd(A_ST, d);
    check("R6 status while off", d, 16'h0000);
    check("R6 sclk idle off", sclk, 0);
    wr(A_C1, 16'h0018);
    wait_idle(n);
    rd(A_ST, d); check("R8 receive full", d[3], 1);
    rd(A_IS, d); check("R8 no overrun at 8", d[2], 0);
    for (int k = 0; k < 8; k++) begin rd(A_DT, d); check("R6 queued word", d, 16'(sent[k])); end
    rd(A_ST, d); check("R6 ninth dropped", d[2], 0);

    // R8 overrun and R9 irq
    wr(A_C1, 16'h001C);
    for (int k = 0; k < 9; k++) begin sent[k] = 8'($urandom); wr(A_DT, 16'(sent[k])); end
    wait_idle(n);
    rd(A_IS, d); check("R8 overrun flag", d[2], 1);
    @(negedge clk); check("R9 irq overrun", irq, 1);
    for (int k = 0; k < 8; k++) begin rd(A_DT, d); check("R8 survivor order", d, 16'(sent[k])); end
    wr(A_IS, 16'h0003); rd(A_IS, d); check("R8 clear needs bit2", d[2], 1);
    wr(A_IS, 16'h0004); rd(A_IS, d); check("R8 cleared", d[2], 0);
    @(negedge clk); check("R9 irq low after clear", irq, 0);
    wr(A_C1, 16'h0019); @(negedge clk); check("R9 rx int empty", irq, 0);
    wr(A_DT, 16'h0011); wait_idle(n);
    @(negedge clk); check("R9 rx int", irq, 1);
    rd(A_DT, d);
    wr(A_C1, 16'h001A); @(negedge clk); check("R9 tx int", irq, 1);
    rd(A_IS, d); check("R9 isr bits", d, 16'h0002);

    // R10 random streaming with coincident pop/push
    wr(A_C1, 16'h0018);
    ns = 0; nr = 0;
    for (int it = 0; it < 20000 && nr < 40; it++) begin
      int r;
      r = $urandom % 3;
      rd(A_ST, d);
      if (d[1] && ns < 40 && r != 0) begin
        sent[ns] = 8'($urandom); wr(A_DT, 16'(sent[ns])); ns++;
      end
      if (d[2] && r != 1) begin
        rd(A_DT, d); check("R10 stream order", d, 16'(sent[nr])); nr++;
      end
    end
    check("R10 stream count", nr, 40);
    rd(A_IS, d); check("R10 no overrun", d[2], 0);

    done = 1;
    summary();
  end
endmodule